// File: doc/BRIEF.md
# Decimal Seven-Segment Display Driver with Error Text

This block presents a 10-bit unsigned number in decimal on a four-position, time-multiplexed seven-segment display. It turns the binary value into decimal digits with a combinational shift-and-add-3 converter. A divided copy of the system clock steps through the four positions one at a time. For the position that is currently lit, it drives the shared segment lines with that position's glyph. If the scan is fast enough (about 60 full refreshes per second), all four positions appear to be lit at the same time.

An error input overrides the number and spells "Err" on the three right-hand positions. The intended use is to show an arithmetic result and switch to the error text when that result has overflowed or underflowed. Anode enables and segment lines are both active-low.

The scan sequencer is a four-state machine: `SLOT_LEFT` (position 3), `SLOT_HUND` (position 2), `SLOT_TENS` (position 1) and `SLOT_ONES` (position 0). The transitions `SLOT_LEFT -> SLOT_HUND`, `SLOT_HUND -> SLOT_TENS`, `SLOT_TENS -> SLOT_ONES` and `SLOT_ONES -> SLOT_LEFT` are each taken on a divider tick, and a state holds while there is no tick. Reset returns the machine to `SLOT_LEFT`.

Top module: `decimal_err_display`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted and on release, the scan is on the leftmost position: `anode_n` = 4'b0111 and the divider count is zero.
- R2: Exactly one bit of `anode_n` is low in every cycle.
- R3: Positions are visited in the order 3, 2, 1, 0, 3, ... (anode_n 0111, 1011, 1101, 1110). Each position stays lit for exactly `SCAN_DIV` clock cycles, so after n rising edges since reset the lit position index from the left is (n / SCAN_DIV) mod 4.
- R4: `seg_n` is active-low with bit 0 = segment a through bit 6 = segment g. Digits 0–9 light the active-high patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex). "E" lights 79, "r" lights 50, and blank lights nothing (seg_n = 7'h7F).
- R5: With `err` low, positions 2, 1 and 0 show the hundreds, tens and ones digits of `value` in decimal. Leading zeros are shown.
- R6: With `err` low, position 3 is blank for values below 1000 and shows digit 1 for values 1000 to 1023.
- R7: With `err` high, position 3 is blank and positions 2, 1 and 0 show "E", "r", "r", whatever `value` is.
- R8: Asserting reset in the middle of a scan returns it to position 3, with a full `SCAN_DIV`-cycle dwell after release.
- R9: The decimal conversion is exact for every input from 0 to 1023: every digit is at most 9, and the weighted sum of the digits equals `value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the divider and scan state |
| value | input | 10 | Unsigned number to display |
| err | input | 1 | High to show "Err" instead of the number |
| anode_n | output | 4 | Active-low position enables, bit 3 = leftmost |
| seg_n | output | 7 | Active-low segment lines, bit 0 = a … bit 6 = g |

## Verification
The assertions assume that `value` and `err` are ordinary two-state levels. They also assume that `SCAN_DIV` is at least 2, so that every dwell spans more than one cycle. The segment checks compare the lit position against the inputs in the same cycle, because the glyph path has no register. The bench therefore changes `value` and `err` only just after a falling edge and samples a little later. Every check then sees inputs that have been stable since the change. The bench uses a divider of 4, which keeps each full scan short enough to sweep all 1024 values.

// File: rtl/dd_pkg.sv
package dd_pkg;

    typedef enum logic [1:0] {
        SLOT_LEFT = 2'd0,
        SLOT_HUND = 2'd1,
        SLOT_TENS = 2'd2,
        SLOT_ONES = 2'd3
    } slot_t;

    typedef enum logic [3:0] {
        GL_0     = 4'd0,
        GL_1     = 4'd1,
        GL_2     = 4'd2,
        GL_3     = 4'd3,
        GL_4     = 4'd4,
        GL_5     = 4'd5,
        GL_6     = 4'd6,
        GL_7     = 4'd7,
        GL_8     = 4'd8,
        GL_9     = 4'd9,
        GL_BLANK = 4'd10,
        GL_E     = 4'd11,
        GL_R     = 4'd12
    } glyph_t;

    localparam int NUM_POS  = 4;
    localparam int SEG_W    = 7;
    localparam int DIGIT_W  = 4;

endpackage

// File: rtl/dd_bcd_conv.sv
module dd_bcd_conv #(
    parameter int VAL_W = 10,
    parameter int NDIG  = 4
) (
    input  logic [VAL_W-1:0]        bin,
    output logic [NDIG*4-1:0]       bcd
);
    localparam int SR_W = VAL_W + 4*NDIG;

    logic [SR_W-1:0] sr;

    always_comb begin
        sr = '0;
        sr[VAL_W-1:0] = bin;
        for (int b = 0; b < VAL_W; b++) begin
            for (int d = 0; d < NDIG; d++) begin
                if (sr[VAL_W + 4*d +: 4] >= 4'd5)
                    sr[VAL_W + 4*d +: 4] = sr[VAL_W + 4*d +: 4] + 4'd3;
            end
            sr = sr << 1;
        end
        bcd = sr[VAL_W +: 4*NDIG];
    end

    // R9: every digit decimal and the weighted sum reproduces the input
    always_comb begin
        int unsigned acc;
        int unsigned wt;
        acc = 0;
        wt  = 1;
        for (int d = 0; d < NDIG; d++) begin
            assert_digit_range_R9: assert (bcd[4*d +: 4] <= 4'd9);
            acc = acc + wt * int'(bcd[4*d +: 4]);
            wt  = wt * 10;
        end
        assert_sum_exact_R9: assert (acc == int'(bin));
    end

endmodule

// File: rtl/dd_scan_timer.sv
module dd_scan_timer #(
    parameter int SCAN_DIV = 416_667
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SCAN_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R3: the count never passes its terminal value
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R1: the count restarts from zero right after reset
    assert_cnt_zero_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0) || !rst_n);

endmodule

// File: rtl/dd_glyph_rom.sv
module dd_glyph_rom
    import dd_pkg::*;
(
    input  glyph_t           glyph,
    output logic [SEG_W-1:0] seg_n
);
    logic [SEG_W-1:0] lit;

    always_comb begin
        unique case (glyph)
            GL_0:     lit = 7'h3F;
            GL_1:     lit = 7'h06;
            GL_2:     lit = 7'h5B;
            GL_3:     lit = 7'h4F;
            GL_4:     lit = 7'h66;
            GL_5:     lit = 7'h6D;
            GL_6:     lit = 7'h7D;
            GL_7:     lit = 7'h07;
            GL_8:     lit = 7'h7F;
            GL_9:     lit = 7'h6F;
            GL_E:     lit = 7'h79;
            GL_R:     lit = 7'h50;
            GL_BLANK: lit = 7'h00;
            default:  lit = 7'h00;
        endcase
    end

    assign seg_n = ~lit;

endmodule

// File: rtl/dd_scan_fsm.sv
module dd_scan_fsm
    import dd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 err,
    input  logic [NUM_POS*4-1:0] bcd,
    output logic [NUM_POS-1:0]   anode_n,
    output glyph_t               glyph
);
    slot_t state, state_nx;

    logic [3:0] d_thou, d_hund, d_tens, d_ones;
    assign d_ones = bcd[3:0];
    assign d_tens = bcd[7:4];
    assign d_hund = bcd[11:8];
    assign d_thou = bcd[15:12];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SLOT_LEFT;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (tick) begin
            unique case (state)
                SLOT_LEFT: state_nx = SLOT_HUND;
                SLOT_HUND: state_nx = SLOT_TENS;
                SLOT_TENS: state_nx = SLOT_ONES;
                SLOT_ONES: state_nx = SLOT_LEFT;
                default:   state_nx = SLOT_LEFT;
            endcase
        end
    end

    always_comb begin
        anode_n = 4'b1111;
        glyph   = GL_BLANK;
        unique case (state)
            SLOT_LEFT: begin
                anode_n = 4'b0111;
                glyph   = (err || d_thou == 4'd0) ? GL_BLANK : glyph_t'(d_thou);
            end
            SLOT_HUND: begin
                anode_n = 4'b1011;
                glyph   = err ? GL_E : glyph_t'(d_hund);
            end
            SLOT_TENS: begin
                anode_n = 4'b1101;
                glyph   = err ? GL_R : glyph_t'(d_tens);
            end
            SLOT_ONES: begin
                anode_n = 4'b1110;
                glyph   = err ? GL_R : glyph_t'(d_ones);
            end
            default: begin
                anode_n = 4'b1111;
                glyph   = GL_BLANK;
            end
        endcase
    end

    // R2: one position lit at a time
    assert_one_anode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~anode_n) == 1);

    // R3: position holds without a tick
    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(anode_n));

    // R3: wrap from rightmost back to leftmost
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && anode_n == 4'b1110) |=> anode_n == 4'b0111);

    // R7: error text never reaches the leftmost position
    assert_err_left_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !anode_n[3]) |-> glyph == GL_BLANK);

endmodule

// File: rtl/decimal_err_display.sv
module decimal_err_display
    import dd_pkg::*;
#(
    parameter int VAL_W    = 10,
    parameter int SCAN_DIV = 416_667
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] value,
    input  logic             err,
    output logic [3:0]       anode_n,
    output logic [6:0]       seg_n
);
    logic                 tick;
    logic [NUM_POS*4-1:0] bcd;
    glyph_t               glyph;

    dd_bcd_conv #(.VAL_W(VAL_W), .NDIG(NUM_POS)) u_conv (
        .bin (value),
        .bcd (bcd)
    );

    dd_scan_timer #(.SCAN_DIV(SCAN_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dd_scan_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .err     (err),
        .bcd     (bcd),
        .anode_n (anode_n),
        .glyph   (glyph)
    );

    dd_glyph_rom u_rom (
        .glyph (glyph),
        .seg_n (seg_n)
    );

    // R6: small numbers leave the leftmost position dark
    assert_left_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && !anode_n[3] && value < 10'd1000) |-> seg_n == 7'h7F);

    // R7: error mode lights the E pattern on position 2
    assert_err_e_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && anode_n == 4'b1011) |-> seg_n == ~7'h79);

endmodule

// File: tb/tb_decimal_err_display.sv
`timescale 1ns/100ps
module tb_decimal_err_display;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] value = '0;
    logic       err = 1'b0;
    logic [3:0] anode_n;
    logic [6:0] seg_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    decimal_err_display #(.VAL_W(10), .SCAN_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .value(value), .err(err),
        .anode_n(anode_n), .seg_n(seg_n)
    );

    function automatic logic [6:0] seg_of(input int g);
        logic [6:0] p;
        case (g)
            0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F;
            4: p = 7'h66; 5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07;
            8: p = 7'h7F; 9: p = 7'h6F; 11: p = 7'h79; 12: p = 7'h50;
            default: p = 7'h00;
        endcase
        return ~p;
    endfunction

    // glyph for position index from the left (0 = leftmost)
    function automatic int glyph_for(input int v, input bit e, input int pos);
        if (e) return (pos == 0) ? 10 : (pos == 1 ? 11 : 12);
        case (pos)
            0: return (v >= 1000) ? v / 1000 : 10;
            1: return (v / 100) % 10;
            2: return (v / 10) % 10;
            default: return v % 10;
        endcase
    endfunction

    function automatic logic [3:0] anode_for(input int pos);
        return ~(4'b1000 >> pos);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pos_of(input logic [3:0] a);
        case (a)
            4'b0111: return 0;
            4'b1011: return 1;
            4'b1101: return 2;
            4'b1110: return 3;
            default: return -1;
        endcase
    endfunction

    // check scan timing for `n` edges after reset release (R3)
    task automatic timing_run(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            chk(anode_n == anode_for(((k + 1) / DIV) % 4), req, {12'h0, anode_n},
                {12'h0, anode_for(((k + 1) / DIV) % 4)});
        end
    endtask

    task automatic sweep_value(input int v, input bit e);
        @(negedge clk);
        value = 10'(v);
        err   = e;
        for (int k = 0; k < 4 * DIV; k++) begin
            int p;
            #1;
            p = pos_of(anode_n);
            chk(p >= 0, "R2", {12'h0, anode_n}, 16'h0);
            if (p >= 0) begin
                if (e)
                    chk(seg_n == seg_of(glyph_for(v, e, p)), "R7", {9'h0, seg_n},
                        {9'h0, seg_of(glyph_for(v, e, p))});
                else if (p == 0)
                    chk(seg_n == seg_of(glyph_for(v, e, p)), "R6", {9'h0, seg_n},
                        {9'h0, seg_of(glyph_for(v, e, p))});
                else
                    chk(seg_n == seg_of(glyph_for(v, e, p)), "R5", {9'h0, seg_n},
                        {9'h0, seg_of(glyph_for(v, e, p))});
            end
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(anode_n == 4'b0111, "R1", {12'h0, anode_n}, 16'h0007);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(anode_n == 4'b0111, "R1", {12'h0, anode_n}, 16'h0007);
        // R3: ordering and dwell
        timing_run(5 * 4 * DIV, "R3");

        // R8: reset mid-scan
        repeat (DIV + 2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(anode_n == 4'b0111, "R8", {12'h0, anode_n}, 16'h0007);
        @(negedge clk);
        rst_n = 1'b1;
        timing_run(2 * 4 * DIV, "R8");

        // R4: glyph encodings on the ones position
        for (int d = 0; d < 10; d++) begin
            @(negedge clk);
            value = 10'(d);
            err = 1'b0;
            while (anode_n != 4'b1110) @(negedge clk);
            #1;
            chk(seg_n == seg_of(d), "R4", {9'h0, seg_n}, {9'h0, seg_of(d)});
        end

        // R5, R6, R9: every value
        for (int v = 0; v < 1024; v++) sweep_value(v, 1'b0);
        // R7: error text over a spread of values
        for (int v = 0; v < 1024; v += 37) sweep_value(v, 1'b1);
        sweep_value(1023, 1'b1);
        // back to number mode right after error
        sweep_value(999, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule